// File: doc/BRIEF.md
# Demodulator Acquisition Controller

This block sequences a broadcast receiver's decoding path from the moment a channel is tuned until clean transport data flows. It watches the segment-sync lock flag from the synchronizer and the mean-square error that the adaptive equalizer reports on its training sequence. From these it decides whether the receiver is hunting for a signal, training the equalizer, or running normally.

The controller has three named states. HUNT (code 0) waits for segment-sync lock. TRAIN (code 1) holds the decoder back-end in reset while the equalizer converges. RUN (code 2) releases the back-end and raises the equalizer-lock flag.

There are four transitions:
- HUNT to TRAIN, named LOCK_FOUND, is taken when segment-sync lock is high.
- TRAIN to RUN, named CONVERGED, is taken when a reported error falls under the programmed threshold.
- Any state to HUNT, named LOCK_LOST, is taken when segment-sync lock drops.
- RUN to RUN with an equalizer restart, named STALL_RESTART, is taken when no good error report arrives within a timeout counted in symbol ticks. It pulses the equalizer reset for exactly one symbol period.

Top module: `acq_ctrl_top`

## Requirements
- R1: While reset is asserted and on release, state_code is 0, and eq_locked, be_reset, eq_reset and mse_last are all 0.
- R2: state_code reports HUNT as 0, TRAIN as 1 and RUN as 2, and never shows 3.
- R3: When seg_lock is low at a clock edge, state_code is 0 after that edge, from any state. This takes priority over every other transition in the same cycle.
- R4: In HUNT, seg_lock high at a clock edge moves the state to TRAIN.
- R5: In TRAIN, with seg_lock high, a cycle with mse_valid high and mse_value strictly below mse_thresh (unsigned) moves the state to RUN. A value equal to or above the threshold leaves the state in TRAIN.
- R6: be_reset is high exactly while the state is TRAIN.
- R7: eq_locked is high exactly while the state is RUN.
- R8: The stall counter starts at 0 on entry to RUN. If it then counts TIMEOUT_TICKS sym_tick cycles with no good error report, eq_reset is high in the cycle after the last of those ticks, and the state stays RUN.
- R9: Once raised, eq_reset stays high until the next sym_tick cycle and is low after that edge, so it lasts one symbol period.
- R10: In RUN, a below-threshold error report clears the stall count, so the next timeout needs TIMEOUT_TICKS further ticks.
- R11: A timeout restarts the stall count. The following timeout fires TIMEOUT_TICKS ticks after the previous one.
- R12: mse_last takes mse_value in the cycle after mse_valid is high and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_lock | input | 1 | Segment-sync lock from the synchronizer |
| sym_tick | input | 1 | One-cycle strobe per symbol period |
| mse_valid | input | 1 | Strobe qualifying mse_value |
| mse_value | input | MSE_W | Training-sequence mean-square error |
| mse_thresh | input | MSE_W | Convergence threshold |
| eq_reset | output | 1 | Equalizer restart, one symbol long |
| be_reset | output | 1 | Back-end decoder hold, high in TRAIN |
| eq_locked | output | 1 | Equalizer lock flag, high in RUN |
| state_code | output | 2 | Current state code |
| mse_last | output | MSE_W | Latest reported error value |

## Verification
Loss of segment-sync lock can arrive in the same cycle as a below-threshold error report while the machine is training. The bench drives both in one cycle and expects HUNT afterwards, with the back-end hold released. A second overlap occurs at the end of an equalizer restart: the tick that ends the restart pulse also counts toward the next timeout. The bench checks this by timing the second restart against the first.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_RUN   = 2'd2
    } acq_state_e;
endpackage

// File: rtl/mse_track.sv
module mse_track #(
    parameter int MSE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mse_valid,
    input  logic [MSE_W-1:0] mse_value,
    input  logic [MSE_W-1:0] mse_thresh,
    output logic             mse_good,
    output logic [MSE_W-1:0] mse_last
);
    // A report is good only when strictly under the threshold
    assign mse_good = mse_valid && (mse_value < mse_thresh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mse_last <= '0;
        else if (mse_valid)
            mse_last <= mse_value;
    end

    AST_MSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mse_valid |=> $stable(mse_last)); // R12
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
    import acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seg_lock,
    input  logic       mse_good,
    output acq_state_e state,
    output logic       be_reset,
    output logic       eq_locked
);
    acq_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (seg_lock) state_nx = ST_TRAIN;        // LOCK_FOUND
            ST_TRAIN: if (mse_good) state_nx = ST_RUN;          // CONVERGED
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_HUNT;
        endcase
        if (!seg_lock) state_nx = ST_HUNT;                      // LOCK_LOST
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HUNT;
        else
            state <= state_nx;
    end

    always_comb begin
        be_reset  = 1'b0;
        eq_locked = 1'b0;
        unique case (state)
            ST_HUNT:  ;
            ST_TRAIN: be_reset  = 1'b1;
            ST_RUN:   eq_locked = 1'b1;
            default:  ;
        endcase
    end

    AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_lock |=> state == ST_HUNT); // R3
    AST_LOCK_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && seg_lock) |=> state == ST_TRAIN); // R4
    AST_CONVERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAIN && seg_lock && mse_good) |=> state == ST_RUN); // R5
    AST_STAY_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAIN && seg_lock && !mse_good) |=> state == ST_TRAIN); // R5
    always_comb begin
        if (rst_n) AST_STATE_LEGAL: assert (state != 2'd3); // R2
    end
endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
    parameter int TIMEOUT_TICKS = 1076000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_run,
    input  logic sym_tick,
    input  logic mse_good,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt;

    assign expire = in_run && !mse_good && sym_tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!in_run || mse_good || expire)
            cnt <= '0;
        else if (sym_tick)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        if (rst_n) AST_NO_OVERFLOW: assert (cnt <= LAST); // R8
    end
    AST_GOOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mse_good |=> cnt == '0); // R10
    AST_EXPIRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt == '0); // R11
endmodule

// File: rtl/eq_pulse.sv
module eq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic sym_tick,
    output logic eq_reset
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            eq_reset <= 1'b0;
        else if (fire)
            eq_reset <= 1'b1;
        else if (sym_tick)
            eq_reset <= 1'b0;
    end

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_reset && !sym_tick) |=> eq_reset); // R9
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_reset && sym_tick && !fire) |=> !eq_reset); // R9
endmodule

// File: rtl/acq_ctrl_top.sv
module acq_ctrl_top
    import acq_pkg::*;
#(
    parameter int MSE_W         = 16,
    parameter int TIMEOUT_TICKS = 1076000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_lock,
    input  logic             sym_tick,
    input  logic             mse_valid,
    input  logic [MSE_W-1:0] mse_value,
    input  logic [MSE_W-1:0] mse_thresh,
    output logic             eq_reset,
    output logic             be_reset,
    output logic             eq_locked,
    output logic [1:0]       state_code,
    output logic [MSE_W-1:0] mse_last
);
    acq_state_e state;
    logic       mse_good;
    logic       expire;

    mse_track #(.MSE_W(MSE_W)) u_mse (
        .clk(clk), .rst_n(rst_n), .mse_valid(mse_valid),
        .mse_value(mse_value), .mse_thresh(mse_thresh),
        .mse_good(mse_good), .mse_last(mse_last)
    );

    acq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .seg_lock(seg_lock), .mse_good(mse_good),
        .state(state), .be_reset(be_reset), .eq_locked(eq_locked)
    );

    stall_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .in_run(state == ST_RUN),
        .sym_tick(sym_tick), .mse_good(mse_good), .expire(expire)
    );

    eq_pulse u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(expire),
        .sym_tick(sym_tick), .eq_reset(eq_reset)
    );

    assign state_code = state;

    AST_RESTART_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eq_reset) |-> $past(state) == ST_RUN); // R8
    AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(eq_locked && be_reset)); // R6
endmodule

// File: tb/tb_acq_ctrl_top.sv
module tb_acq_ctrl_top;
    localparam int W  = 16;
    localparam int TO = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seg_lock = 1'b0, sym_tick = 1'b0, mse_valid = 1'b0;
    logic [W-1:0] mse_value = '0, mse_thresh = 16'd100;
    logic         eq_reset, be_reset, eq_locked;
    logic [1:0]   state_code;
    logic [W-1:0] mse_last;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acq_ctrl_top #(.MSE_W(W), .TIMEOUT_TICKS(TO)) dut (
        .clk(clk), .rst_n(rst_n), .seg_lock(seg_lock), .sym_tick(sym_tick),
        .mse_valid(mse_valid), .mse_value(mse_value), .mse_thresh(mse_thresh),
        .eq_reset(eq_reset), .be_reset(be_reset), .eq_locked(eq_locked),
        .state_code(state_code), .mse_last(mse_last)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        sym_tick = 1'b1; step(1); sym_tick = 1'b0;
    endtask

    task automatic report(input logic [W-1:0] v);
        mse_valid = 1'b1; mse_value = v; step(1); mse_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; seg_lock = 1'b0; sym_tick = 1'b0; mse_valid = 1'b0;
        step(2); rst_n = 1'b1; step(1);
    endtask

    task automatic go_run();
        do_reset();
        seg_lock = 1'b1; step(1);
        report(16'd10);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mse_valid = 1'b1; mse_value = 16'h55; seg_lock = 1'b1;
        step(2);
        chk("R1 state", state_code, 0);
        chk("R1 eq_locked", eq_locked, 0);
        chk("R1 be_reset", be_reset, 0);
        chk("R1 eq_reset", eq_reset, 0);
        chk("R1 mse_last", mse_last, 0);
        mse_valid = 1'b0; seg_lock = 1'b0;
        rst_n = 1'b1; step(1);
        chk("R1 state after release", state_code, 0);
    endtask

    task automatic t_acquire();
        do_reset();
        step(3);
        chk("R4 hunt without lock", state_code, 0);
        seg_lock = 1'b1; step(1);
        chk("R4 R2 train code", state_code, 1);
        chk("R6 be_reset in train", be_reset, 1);
        chk("R7 not locked in train", eq_locked, 0);
        report(16'd100);
        chk("R5 equal stays train", state_code, 1);
        report(16'd900);
        chk("R5 above stays train", state_code, 1);
        report(16'd99);
        chk("R5 R2 run code", state_code, 2);
        chk("R7 locked in run", eq_locked, 1);
        chk("R6 be_reset off in run", be_reset, 0);
    endtask

    task automatic t_lock_loss();
        go_run();
        seg_lock = 1'b0; step(1);
        chk("R3 run to hunt", state_code, 0);
        chk("R7 unlock on loss", eq_locked, 0);
        seg_lock = 1'b1; step(1);
        chk("R4 reacquire", state_code, 1);
        // collision: lock loss and good error in the same training cycle
        seg_lock = 1'b0; report(16'd1);
        chk("R3 loss beats converge", state_code, 0);
        chk("R6 hold released in hunt", be_reset, 0);
    endtask

    task automatic t_timeout();
        go_run();
        repeat (TO - 1) tick();
        chk("R8 no restart early", eq_reset, 0);
        tick();
        chk("R8 restart raised", eq_reset, 1);
        chk("R8 stays run", state_code, 2);
        step(1);
        chk("R9 held without tick", eq_reset, 1);
        tick();
        chk("R9 dropped after tick", eq_reset, 0);
        repeat (TO - 2) tick();
        chk("R11 no second restart early", eq_reset, 0);
        tick();
        chk("R11 second restart", eq_reset, 1);
    endtask

    task automatic t_good_clears();
        go_run();
        repeat (TO - 3) tick();
        report(16'd5);
        repeat (TO - 1) tick();
        chk("R10 count cleared", eq_reset, 0);
        report(16'd500);
        tick();
        chk("R10 bad report does not clear", eq_reset, 1);
    endtask

    task automatic t_capture();
        do_reset();
        report(16'hBEEF);
        chk("R12 captured", mse_last, 16'hBEEF);
        mse_value = 16'h1234; step(2);
        chk("R12 held", mse_last, 16'hBEEF);
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_lock_loss();
        t_timeout();
        t_good_clears();
        t_capture();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule